// File: doc/BRIEF.md
# Cluster Performance and Power Request Controller

This register block sits on a simple 32-bit register bus and takes performance and power requests for a processor system with two clusters. A write of a level index to either cluster's performance register starts a performance change. A write to the command register with its start bit set starts a lookup in an internal table of operating-point words. Each accepted request runs for a fixed number of clock cycles. The block then posts a completion or an error flag for that request type in one status word and raises a level interrupt.

The block also holds several plain registers that steer power management elsewhere on the chip. These are a wake-up interrupt mask, one power-down enable per cluster and a 32-bit resume-address mailbox for each CPU. It also returns a read-only word that gathers the standby-in-WFI flags of every CPU. Software starts one request, waits for the interrupt, and reads the status word. That read acknowledges the request and clears the status word.

Top module: `pwr_perf_ctrl`

## Requirements
- R1: After reset every register reads zero, `irq` is low, and `wake_mask`, `pwrdn_a` and `pwrdn_b` are zero. A read of an unmapped word address returns zero, and `rdata` is zero while `rd_en` is low.
- R2: A write to byte address 0x00 (cluster A, OPPS_A table entries) or 0x08 (cluster B, OPPS_B entries) with a value below that cluster's entry count is accepted when the block is idle. Exactly LATENCY clock edges after the accepting edge, status bit 0 (cluster A) or bit 4 (cluster B) is set. The register reads back the accepted index from the next cycle on.
- R3: A write to 0x00 or 0x08 with a value equal to or above the entry count is accepted as a request. LATENCY edges later it sets status bit 1 (cluster A) or bit 5 (cluster B), and the performance register keeps its earlier value.
- R4: A write to 0x10 with bit 31 set, function code 6 in bits 23:20 and a word offset in bits 9:0 starts a table read. Offsets 0x304 to 0x304+OPPS_A-1 select cluster A entry i = offset-0x304. Offsets 0x30C to 0x30C+OPPS_B-1 select cluster B entry i = offset-0x30C. LATENCY edges later status bit 8 is set and 0x74 returns the word, with the frequency in 20 kHz units in bits 19:0 and millivolts in bits 31:20. Cluster A entries hold 50000+2500*i units at 900+25*i mV. Cluster B entries hold 30000+2500*i units at 850+25*i mV.
- R5: A table read with any other function code, or with an offset outside the populated entries, sets status bit 9 instead of bit 8 and leaves 0x74 unchanged. A write to 0x10 with bit 31 clear starts nothing and posts no status.
- R6: While a request is in flight, a new request does not change the operation in flight or any performance register. It sets the error bit (4*type+1) of its own type on the next edge: type 0 is cluster A, type 1 is cluster B, type 2 is the table read.
- R7: `irq` is high exactly while any status bit is set. A read of 0x18 returns the status word and clears it. A bit posted on the same edge as the clearing read survives the clear.
- R8: The wake-up mask at 0x24 stores bit cpu for each cluster A CPU, bit 4+cpu for each cluster B CPU, and the global enables in bits 11:10. All other bits read zero, and the stored value drives `wake_mask`.
- R9: Bit 0 of 0x30 and bit 0 of 0x34 are the power-down enables that drive `pwrdn_a` and `pwrdn_b`.
- R10: The word at 0x3C returns `wfi_a[cpu]` at bit cpu and `wfi_b[cpu]` at bit 3+cpu, with all other bits zero.
- R11: The resume-address mailboxes sit at 0x68+4*cpu for cluster A and at 0x78+4*cpu for cluster B. Each stores a full 32-bit write and returns it on a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address; bits 1:0 ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` while `rd_en` is high |
| wfi_a | input | CPUS_A | Standby-in-WFI flags of cluster A CPUs |
| wfi_b | input | CPUS_B | Standby-in-WFI flags of cluster B CPUs |
| irq | output | 1 | Level interrupt, high while any status bit is set |
| wake_mask | output | 12 | Stored wake-up interrupt mask |
| pwrdn_a | output | 1 | Cluster A power-down enable |
| pwrdn_b | output | 1 | Cluster B power-down enable |

## Verification
A wrong busy flag or a wrong latency counter shows on `irq` within LATENCY+1 cycles of a request. It shows as an interrupt that rises one edge early or late, never rises, or rises on a busy error that should not exist. A wrong request type or a wrong validity decision appears in the status word at the first read after the operation finishes. A corrupted performance index, table word or mailbox shows only when that address is next read. For that reason the bench reads these registers back directly after every change.

// File: rtl/pwr_perf_ctrl.sv
module pwr_perf_ctrl #(
  parameter int LATENCY = 4,
  parameter int CPUS_A  = 2,
  parameter int CPUS_B  = 3,
  parameter int OPPS_A  = 5,
  parameter int OPPS_B  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [11:0]       addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [CPUS_A-1:0] wfi_a,
  input  logic [CPUS_B-1:0] wfi_b,
  output logic              irq,
  output logic [11:0]       wake_mask,
  output logic              pwrdn_a,
  output logic              pwrdn_b
);
  localparam int CW = $clog2(LATENCY + 1);
  localparam logic [9:0] W_PA = 10'h000, W_PB = 10'h002, W_CMD = 10'h004, W_STAT = 10'h006;
  localparam logic [9:0] W_WAKE = 10'h009, W_PDA = 10'h00C, W_PDB = 10'h00D, W_WFI = 10'h00F;
  localparam logic [9:0] W_MBA = 10'h01A, W_CDAT = 10'h01D, W_MBB = 10'h01E;
  localparam logic [9:0] TAB_A = 10'h304, TAB_B = 10'h30C;
  localparam logic [11:0] WAKE_OK = 12'hC00 | 12'((1 << CPUS_A) - 1) | 12'(((1 << CPUS_B) - 1) << 4);

  function automatic logic [31:0] opp_word(input logic cb, input logic [2:0] i);
    logic [19:0] f;
    logic [11:0] mv;
    f  = (cb ? 20'd30000 : 20'd50000) + 20'd2500 * {17'd0, i};
    mv = (cb ? 12'd850 : 12'd900) + 12'd25 * {9'd0, i};
    return {mv, f};
  endfunction

  logic [9:0]  wa, off;
  logic        req_a, req_b, req_c, req_any, req_ok, in_a, in_b, done;
  logic [1:0]  req_t, typ;
  logic        busy, err;
  logic [CW-1:0] cnt;
  logic [31:0] pend, cdata;
  logic [2:0]  perf_a, perf_b, idx;
  logic [11:0] status, set_bits;
  logic [7:0]  wfi_word;
  logic [31:0] mb_a [CPUS_A];
  logic [31:0] mb_b [CPUS_B];
  logic        unused_bits;

  assign wa      = addr[11:2];
  assign off     = wdata[9:0];
  assign req_a   = wr_en && wa == W_PA;
  assign req_b   = wr_en && wa == W_PB;
  assign req_c   = wr_en && wa == W_CMD && wdata[31];
  assign req_any = req_a || req_b || req_c;
  assign req_t   = req_a ? 2'd0 : req_b ? 2'd1 : 2'd2;
  assign in_a    = off >= TAB_A && off < TAB_A + 10'(OPPS_A);
  assign in_b    = off >= TAB_B && off < TAB_B + 10'(OPPS_B);
  assign idx     = in_a ? 3'(off - TAB_A) : 3'(off - TAB_B);
  assign req_ok  = req_a ? wdata < 32'(OPPS_A) :
                   req_b ? wdata < 32'(OPPS_B) :
                   (wdata[23:20] == 4'd6 && (in_a || in_b));
  assign done    = busy && cnt == '0;
  assign irq     = |status;
  assign unused_bits = ^{addr[1:0], wdata[30:24], wdata[19:10]};

  always_comb begin
    set_bits = '0;
    if (done) set_bits[{typ, 2'b00} + {3'b000, err}] = 1'b1;
    if (req_any && busy) set_bits[{req_t, 2'b01}] = 1'b1;
  end

  always_comb begin
    wfi_word = '0;
    wfi_word[CPUS_A-1:0] = wfi_a;
    wfi_word[3+CPUS_B-1:3] = wfi_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; err <= 1'b0; typ <= '0; cnt <= '0; pend <= '0; cdata <= '0;
      perf_a <= '0; perf_b <= '0; status <= '0; wake_mask <= '0;
      pwrdn_a <= 1'b0; pwrdn_b <= 1'b0;
      for (int i = 0; i < CPUS_A; i++) mb_a[i] <= '0;
      for (int i = 0; i < CPUS_B; i++) mb_b[i] <= '0;
    end else begin
      status <= ((rd_en && wa == W_STAT) ? 12'd0 : status) | set_bits;
      if (done) begin
        busy <= 1'b0;
        if (typ == 2'd2 && !err) cdata <= pend;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
      if (req_any && !busy) begin
        busy <= 1'b1;
        typ  <= req_t;
        err  <= !req_ok;
        cnt  <= CW'(LATENCY - 1);
        pend <= opp_word(in_b && !in_a, idx);
        if (req_a && req_ok) perf_a <= wdata[2:0];
        if (req_b && req_ok) perf_b <= wdata[2:0];
      end
      if (wr_en) begin
        if (wa == W_WAKE) wake_mask <= wdata[11:0] & WAKE_OK;
        if (wa == W_PDA) pwrdn_a <= wdata[0];
        if (wa == W_PDB) pwrdn_b <= wdata[0];
        for (int i = 0; i < CPUS_A; i++) if (wa == W_MBA + 10'(i)) mb_a[i] <= wdata;
        for (int i = 0; i < CPUS_B; i++) if (wa == W_MBB + 10'(i)) mb_b[i] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (wa)
        W_PA:    rdata = {29'd0, perf_a};
        W_PB:    rdata = {29'd0, perf_b};
        W_STAT:  rdata = {20'd0, status};
        W_WAKE:  rdata = {20'd0, wake_mask};
        W_PDA:   rdata = {31'd0, pwrdn_a};
        W_PDB:   rdata = {31'd0, pwrdn_b};
        W_WFI:   rdata = {24'd0, wfi_word};
        W_CDAT:  rdata = cdata;
        default: rdata = '0;
      endcase
      for (int i = 0; i < CPUS_A; i++) if (wa == W_MBA + 10'(i)) rdata = mb_a[i];
      for (int i = 0; i < CPUS_B; i++) if (wa == W_MBB + 10'(i)) rdata = mb_b[i];
    end
  end
endmodule

// File: rtl/pwr_perf_ctrl_chk.sv
module pwr_perf_ctrl_chk #(
  parameter int LATENCY = 4,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [11:0]   addr,
  input logic          irq,
  input logic          busy,
  input logic          done,
  input logic [CW-1:0] cnt,
  input logic [2:0]    perf_a
);
  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[11:2] == 10'h000 && !busy) |=> busy);
  // R2
  latency_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (32'(cnt) < LATENCY));
  // R6
  busy_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[11:2] == 10'h002 && busy) |=> irq);
  // R7
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr[11:2] == 10'h006 && !done) |=> !irq);
  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(done) || $past(wr_en)));
  // R3
  perf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr[11:2] == 10'h000) |=> $stable(perf_a));
endmodule

bind pwr_perf_ctrl pwr_perf_ctrl_chk #(.LATENCY(LATENCY), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .irq(irq), .busy(busy), .done(done), .cnt(cnt), .perf_a(perf_a)
);

// File: tb/test_pwr_perf_ctrl.sv
module test_pwr_perf_ctrl;
  localparam int LAT = 4, CA = 2, CB = 3, OA = 5, OB = 4;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [CA-1:0] wfi_a = '0;
  logic [CB-1:0] wfi_b = '0;
  logic irq, pwrdn_a, pwrdn_b;
  logic [11:0] wake_mask;
  int checks = 0, errors = 0;

  pwr_perf_ctrl #(.LATENCY(LAT), .CPUS_A(CA), .CPUS_B(CB), .OPPS_A(OA), .OPPS_B(OB)) i_pwr_perf_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .wfi_a(wfi_a), .wfi_b(wfi_b), .irq(irq), .wake_mask(wake_mask),
    .pwrdn_a(pwrdn_a), .pwrdn_b(pwrdn_b));

  always #10 clk = ~clk;

  // behavioural reference state
  logic [31:0] m_perf [2];
  logic [31:0] m_status, m_wake, m_pda, m_pdb, m_cdata, m_pend;
  logic [31:0] m_mba [CA];
  logic [31:0] m_mbb [CB];
  bit m_busy, m_err;
  int m_cnt, m_type;

  function automatic logic [31:0] ref_opp(int c, int i);
    int f, mv;
    f  = (c == 1 ? 30000 : 50000) + 2500 * i;
    mv = (c == 1 ? 850 : 900) + 25 * i;
    return (32'(mv) << 20) | 32'(f);
  endfunction

  function automatic logic [31:0] ref_wake_ok();
    logic [31:0] v = 32'hC00;
    for (int i = 0; i < CA; i++) v[i] = 1'b1;
    for (int i = 0; i < CB; i++) v[4+i] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] exp_read(int w);
    for (int i = 0; i < CA; i++) if (w == 'h1A + i) return m_mba[i];
    for (int i = 0; i < CB; i++) if (w == 'h1E + i) return m_mbb[i];
    case (w)
      'h00: return m_perf[0];
      'h02: return m_perf[1];
      'h06: return m_status;
      'h09: return m_wake;
      'h0C: return m_pda;
      'h0D: return m_pdb;
      'h0F: return 32'(wfi_a) | (32'(wfi_b) << 3);
      'h1D: return m_cdata;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_perf[0] = 0; m_perf[1] = 0; m_status = 0; m_wake = 0; m_pda = 0; m_pdb = 0;
      m_cdata = 0; m_pend = 0; m_busy = 0; m_err = 0; m_cnt = 0; m_type = 0;
      for (int i = 0; i < CA; i++) m_mba[i] = 0;
      for (int i = 0; i < CB; i++) m_mbb[i] = 0;
    end else begin
      int w, rt, off;
      bit ok, was_busy;
      logic [31:0] setb, word;
      w = int'(addr >> 2); rt = -1; ok = 0; word = 0; setb = 0; was_busy = m_busy;
      if (wr_en && w == 0) begin rt = 0; ok = wdata < OA; end
      if (wr_en && w == 2) begin rt = 1; ok = wdata < OB; end
      if (wr_en && w == 4 && wdata[31]) begin
        rt = 2; off = int'(wdata & 32'h3FF);
        if (((wdata >> 20) & 15) == 6 && off >= 'h304 && off < 'h304 + OA) begin ok = 1; word = ref_opp(0, off - 'h304); end
        if (((wdata >> 20) & 15) == 6 && off >= 'h30C && off < 'h30C + OB) begin ok = 1; word = ref_opp(1, off - 'h30C); end
      end
      if (m_busy) begin
        if (m_cnt == 0) begin
          setb |= 32'(1) << (4 * m_type + (m_err ? 1 : 0));
          if (m_type == 2 && !m_err) m_cdata = m_pend;
          m_busy = 0;
        end else m_cnt--;
      end
      if (rt >= 0) begin
        if (was_busy) setb |= 32'(1) << (4 * rt + 1);
        else begin
          m_busy = 1; m_type = rt; m_err = !ok; m_pend = word; m_cnt = LAT - 1;
          if (ok && rt < 2) m_perf[rt] = wdata;
        end
      end
      m_status = ((rd_en && w == 6) ? 0 : m_status) | setb;
      if (wr_en) begin
        if (w == 'h09) m_wake = wdata & ref_wake_ok();
        if (w == 'h0C) m_pda = wdata & 1;
        if (w == 'h0D) m_pdb = wdata & 1;
        for (int i = 0; i < CA; i++) if (w == 'h1A + i) m_mba[i] = wdata;
        for (int i = 0; i < CB; i++) if (w == 'h1E + i) m_mbb[i] = wdata;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R7 irq", 32'(irq), 32'(m_status != 0));
    chk("R8 wake_mask", 32'(wake_mask), m_wake);
    chk("R9 pwrdn_a", 32'(pwrdn_a), m_pda);
    chk("R9 pwrdn_b", 32'(pwrdn_b), m_pdb);
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(string req, logic [11:0] a);
    @(negedge clk); rd_en = 1; addr = a; #1;
    chk(req, rdata, exp_read(int'(a >> 2)));
    @(negedge clk); rd_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1; chk("R1 irq reset", 32'(irq), 0);
    chk("R1 rdata idle", rdata, 0);
    rst_n = 1;
    rd("R1 perf_a", 12'h000); rd("R1 perf_b", 12'h008); rd("R1 status", 12'h018);
    rd("R1 wake", 12'h024); rd("R1 cdata", 12'h074); rd("R1 unmapped", 12'h040);
    // R2 valid performance changes
    wr(12'h000, 2); idle(LAT + 1); rd("R2 status A", 12'h018); rd("R2 perf_a", 12'h000);
    wr(12'h008, 3); idle(LAT + 1); rd("R2 status B", 12'h018); rd("R2 perf_b", 12'h008);
    wr(12'h000, OA - 1); idle(LAT + 1); rd("R2 top index", 12'h018); rd("R2 perf_a top", 12'h000);
    // R3 invalid indices
    wr(12'h000, OA); idle(LAT + 1); rd("R3 status A", 12'h018); rd("R3 perf_a kept", 12'h000);
    wr(12'h008, 32'h100); idle(LAT + 1); rd("R3 status B", 12'h018); rd("R3 perf_b kept", 12'h008);
    // R4 table reads
    wr(12'h010, 32'h8060_0305); idle(LAT + 1); rd("R4 status", 12'h018); rd("R4 word A1", 12'h074);
    wr(12'h010, 32'h8060_030F); idle(LAT + 1); rd("R4 status", 12'h018); rd("R4 word B3", 12'h074);
    wr(12'h010, 32'h8060_0304); idle(LAT + 1); rd("R4 status", 12'h018); rd("R4 word A0", 12'h074);
    // R5 bad table reads
    wr(12'h010, 32'h8050_0304); idle(LAT + 1); rd("R5 bad func", 12'h018); rd("R5 data kept", 12'h074);
    wr(12'h010, 32'h8060_0309); idle(LAT + 1); rd("R5 bad offset", 12'h018); rd("R5 data kept", 12'h074);
    wr(12'h010, 32'h0060_0305); idle(LAT + 1); rd("R5 no start", 12'h018);
    // R6 request while busy
    wr(12'h000, 1); wr(12'h008, 0); rd("R6 busy error", 12'h018);
    rd("R6 perf_b kept", 12'h008); idle(LAT); rd("R6 in-flight done", 12'h018); rd("R6 perf_a", 12'h000);
    wr(12'h000, 3); wr(12'h010, 32'h8060_0304); rd("R6 type2 busy", 12'h018); idle(LAT); rd("R6 done", 12'h018);
    // R7 clear on the posting edge
    wr(12'h000, 4); idle(LAT - 2); rd("R7 clear race", 12'h018); rd("R7 survives", 12'h018);
    rd("R7 cleared", 12'h018);
    // R8 wake mask
    wr(12'h024, 32'hFFFF_FFFF); rd("R8 wake", 12'h024);
    wr(12'h024, 32'h0000_0410); rd("R8 wake partial", 12'h024);
    // R9 power-down enables
    wr(12'h030, 32'hFFFF_FFFF); rd("R9 pda", 12'h030);
    wr(12'h034, 1); rd("R9 pdb", 12'h034); wr(12'h030, 0); rd("R9 pda off", 12'h030);
    // R10 standby word
    wfi_a = 2'b10; wfi_b = 3'b101; rd("R10 wfi", 12'h03C);
    wfi_a = 2'b01; wfi_b = 3'b010; rd("R10 wfi", 12'h03C);
    // R11 mailboxes
    for (int i = 0; i < CA; i++) wr(12'h068 + 12'(4 * i), 32'hA000_0000 + 32'(i));
    for (int i = 0; i < CB; i++) wr(12'h078 + 12'(4 * i), 32'hB000_1000 + 32'(i));
    for (int i = 0; i < CA; i++) rd("R11 mailbox A", 12'h068 + 12'(4 * i));
    for (int i = 0; i < CB; i++) rd("R11 mailbox B", 12'h078 + 12'(4 * i));
    idle(4);
    finish_run();
  end
endmodule